// File: doc/BRIEF.md
# SPI Master with Per-Word Control

This block is the shifting core of an SPI master in mode 0: the clock idles low, the outgoing bit is set up while the clock is low, and the incoming bit is captured on the rising edge. Software or a sequencer hands it one command at a time. Each command holds up to sixteen data bits together with its own length code and three per-word flags: release slave select after this word, insert a frame gap after this word, and discard what comes back during this word.

A single holding register sits in front of the shifter. A new command is taken while the previous one is still on the wire, which lets a long transfer be built from several back-to-back words with slave select held low throughout. Received words are right-aligned and parked in a receive register. A word that wants its reply kept waits until that register has been read. A word that discards its reply runs regardless.

Three inputs set the timing. `half_div` gives the SCK half period in clock cycles. `frame_dly` and `xfer_dly` give the frame gap and the post-release gap, both counted in whole SCK periods.

Top module: `spi_word_master`

## Requirements
- R1: A command with length code L (`cmd_len`) shifts exactly L+1 bits on `mosi`, most significant of those bits first, so code 0 sends 1 bit and code 15 sends 16 bits. Each bit is driven while `sck` is low and held while `sck` is high. `sck` is low whenever `ssel_n` is high.
- R2: The bits on `miso` are captured on rising `sck` edges into a word right-aligned to its length. When receive-discard is clear, `rx_valid` rises after the last bit, and a one-cycle `rx_read` pulse clears it.
- R3: With the release flag set, `ssel_n` goes high after the last bit. If the next command is already waiting, `ssel_n` stays high for exactly 2*`xfer_dly`*(`half_div`+1)+1 clock cycles before it falls again.
- R4: With the release flag clear, `ssel_n` stays low into the next word. The low time of `sck` between the two words is `half_div`+2 clock cycles.
- R5: With the frame flag set and the release flag clear, `sck` stays low with `ssel_n` low for 2*`frame_dly`*(`half_div`+1)+`half_div`+2 clock cycles before the first rising edge of the next word.
- R6: With `frame_dly` at zero, the frame flag has no effect on timing.
- R7: When a word carries both flags, the high time of `ssel_n` is set by the larger of `frame_dly` and `xfer_dly`.
- R8: A word with receive-discard set leaves `rx_valid` and `rx_data` untouched, and it starts even while an unread word is waiting.
- R9: A word with receive-discard clear does not start while `rx_valid` is high. It starts once the pending word has been read.
- R10: `cmd_ready` is high whenever the holding register is empty, so a second command is accepted while the first is still shifting.
- R11: Each `sck` half period lasts `half_div`+1 clock cycles. On a fresh start, `ssel_n` falls one half period before the first rising `sck` edge.
- R12: `busy` is high while a command waits, while a word shifts, during any gap, and whenever `ssel_n` is low.
- R13: After reset, `ssel_n` is 1, `sck` is 0, `busy` is 0, `rx_valid` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_div | input | DIV_W (8) | SCK half period minus one, in clock cycles |
| frame_dly | input | DLY_W (8) | Frame gap in SCK periods |
| xfer_dly | input | DLY_W (8) | Minimum slave-select high time in SCK periods |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Holding register empty |
| cmd_data | input | DATA_W (16) | Data, right-aligned |
| cmd_len | input | LEN_W (4) | Bit count minus one |
| cmd_eot | input | 1 | Release slave select after this word |
| cmd_eof | input | 1 | Insert frame gap after this word |
| cmd_rxign | input | 1 | Discard the reply of this word |
| rx_read | input | 1 | Pop the receive register |
| rx_valid | output | 1 | Receive register full |
| rx_data | output | DATA_W (16) | Received word, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel_n | output | 1 | Slave select, active low |
| busy | output | 1 | Engine active |

## Verification
A word can end with both the release and the frame flag set, so two gap lengths compete in the same cycle. The bench sets both flags on one word, under both orderings of the two delay values. It then checks that the high time of `ssel_n` matches the larger one. A second collision is a new command waiting in the holding register at the moment an unread receive word is still pending. The bench issues a keep-reply word behind an unread word and checks that it stalls. It issues a discard word in the same position and checks that it runs without disturbing `rx_data`.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_GAP  = 2'd3
    } eng_st_e;
endpackage

// File: rtl/spi_wm_hold.sv
module spi_wm_hold #(
    parameter int WORD_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              take,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take) begin
            h_d.vld = 1'b0;
        end
        if (in_valid && !h_q.vld) begin
            h_d.vld  = 1'b1;
            h_d.word = in_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign in_ready  = !h_q.vld;
    assign out_valid = h_q.vld;
    assign out_word  = h_q.word;

    // R10: the engine only pulls a word that is actually held
    assert_take_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> h_q.vld);
endmodule

// File: rtl/spi_wm_tick.sv
module spi_wm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = !clr && (cnt_q >= half_div);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (clr || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R11: with a non-zero divider two ticks never come back to back
    assert_tick_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (half_div != '0) |=> !tick || (half_div != $past(half_div)));
endmodule

// File: rtl/spi_wm_rx.sv
module spi_wm_rx #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put,
    input  logic [DATA_W-1:0] put_data,
    input  logic              pop,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] word;
    } rxh_t;

    rxh_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (pop) begin
            r_d.vld = 1'b0;
        end
        if (put) begin
            r_d.vld  = 1'b1;
            r_d.word = put_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign valid = r_q.vld;
    assign data  = r_q.word;

    // R9: a kept reply never lands on an unread one
    assert_put_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        put |-> !r_q.vld);
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_wm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DIV_W-1:0]           half_div,
    input  logic [DLY_W-1:0]           frame_dly,
    input  logic [DLY_W-1:0]           xfer_dly,
    input  logic                       cmd_valid,
    output logic                       cmd_ready,
    input  logic [DATA_W-1:0]          cmd_data,
    input  logic [$clog2(DATA_W)-1:0]  cmd_len,
    input  logic                       cmd_eot,
    input  logic                       cmd_eof,
    input  logic                       cmd_rxign,
    input  logic                       rx_read,
    output logic                       rx_valid,
    output logic [DATA_W-1:0]          rx_data,
    output logic                       sck,
    output logic                       mosi,
    input  logic                       miso,
    output logic                       ssel_n,
    output logic                       busy
);
    localparam int LEN_W  = $clog2(DATA_W);
    localparam int WORD_W = DATA_W + LEN_W + 3;
    localparam int CNT_W  = DLY_W + 1;
    localparam int IGN_B  = DATA_W + LEN_W;

    typedef struct packed {
        eng_st_e           st;
        logic              ssel_n;
        logic              sck;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [LEN_W-1:0]  bits;
        logic              eot;
        logic              eof;
        logic              ign;
        logic [CNT_W-1:0]  dcnt;
    } eng_t;

    eng_t e_d, e_q;

    logic              h_vld;
    logic [WORD_W-1:0] h_word;
    logic              take;
    logic              tick;
    logic              tick_clr;
    logic              rx_put;

    logic [DATA_W-1:0] h_data;
    logic [LEN_W-1:0]  h_len;
    logic              h_ign, h_eof, h_eot;
    logic [LEN_W:0]    h_sh;
    logic [DLY_W-1:0]  gap;
    logic              start_ok;

    spi_wm_hold #(.WORD_W(WORD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (cmd_valid),
        .in_ready (cmd_ready),
        .in_word  ({cmd_eot, cmd_eof, cmd_rxign, cmd_len, cmd_data}),
        .take     (take),
        .out_valid(h_vld),
        .out_word (h_word)
    );

    spi_wm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tick_clr),
        .half_div(half_div),
        .tick    (tick)
    );

    spi_wm_rx #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .put     (rx_put),
        .put_data(e_q.rx),
        .pop     (rx_read),
        .valid   (rx_valid),
        .data    (rx_data)
    );

    assign h_data = h_word[DATA_W-1:0];
    assign h_len  = h_word[DATA_W +: LEN_W];
    assign h_ign  = h_word[IGN_B];
    assign h_eof  = h_word[IGN_B + 1];
    assign h_eot  = h_word[IGN_B + 2];
    assign h_sh   = (LEN_W + 1)'(DATA_W - 1) - {1'b0, h_len};

    // a kept-reply word waits for the receive register to drain
    assign start_ok = h_vld && (h_ign || !rx_valid);
    assign tick_clr = (e_q.st == ST_IDLE);

    always_comb begin
        if (e_q.eot) begin
            gap = (e_q.eof && (frame_dly > xfer_dly)) ? frame_dly : xfer_dly;
        end else if (e_q.eof) begin
            gap = frame_dly;
        end else begin
            gap = '0;
        end
    end

    always_comb begin
        e_d    = e_q;
        take   = 1'b0;
        rx_put = 1'b0;
        unique case (e_q.st)
            ST_IDLE: begin
                if (start_ok) begin
                    take       = 1'b1;
                    e_d.st     = ST_LOW;
                    e_d.ssel_n = 1'b0;
                    e_d.sck    = 1'b0;
                    e_d.tx     = h_data << h_sh;
                    e_d.rx     = '0;
                    e_d.bits   = h_len;
                    e_d.eot    = h_eot;
                    e_d.eof    = h_eof;
                    e_d.ign    = h_ign;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    e_d.sck = 1'b1;
                    e_d.rx  = {e_q.rx[DATA_W-2:0], miso};
                    e_d.st  = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    e_d.sck = 1'b0;
                    if (e_q.bits != '0) begin
                        e_d.bits = e_q.bits - 1'b1;
                        e_d.tx   = e_q.tx << 1;
                        e_d.st   = ST_LOW;
                    end else begin
                        rx_put = !e_q.ign;
                        if (e_q.eot) begin
                            e_d.ssel_n = 1'b1;
                        end
                        if (gap != '0) begin
                            e_d.dcnt = {gap, 1'b0};
                            e_d.st   = ST_GAP;
                        end else begin
                            e_d.st = ST_IDLE;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (e_q.dcnt == CNT_W'(1)) begin
                        e_d.st = ST_IDLE;
                    end else begin
                        e_d.dcnt = e_q.dcnt - 1'b1;
                    end
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q        <= '0;
            e_q.st     <= ST_IDLE;
            e_q.ssel_n <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign sck    = e_q.sck;
    assign mosi   = e_q.tx[DATA_W-1];
    assign ssel_n = e_q.ssel_n;
    assign busy   = h_vld || (e_q.st != ST_IDLE) || !e_q.ssel_n;

    // R1: clock idles low while no slave is selected
    assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ssel_n |-> !sck);

    // R1: data out does not move while the clock is high
    assert_mosi_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sck && $past(sck) |-> $stable(mosi));

    // R12: a selected slave always shows as busy
    assert_busy_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ssel_n |-> busy);

    // R9: a kept-reply word never starts over an unread reply
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take && !h_ign |-> !rx_valid);

    // R3: slave select is only released by a word carrying the release flag
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ssel_n) |-> $past(e_q.eot));
endmodule

// File: tb/spi_word_master_tb.sv
module spi_word_master_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  half_div, frame_dly, xfer_dly;
    logic        cmd_valid, cmd_ready;
    logic [15:0] cmd_data;
    logic [3:0]  cmd_len;
    logic        cmd_eot, cmd_eof, cmd_rxign;
    logic        rx_read, rx_valid;
    logic [15:0] rx_data;
    logic        sck, mosi, miso, ssel_n, busy;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    spi_word_master u_dut (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .frame_dly(frame_dly),
        .xfer_dly(xfer_dly), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .cmd_len(cmd_len), .cmd_eot(cmd_eot),
        .cmd_eof(cmd_eof), .cmd_rxign(cmd_rxign), .rx_read(rx_read),
        .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck), .mosi(mosi),
        .miso(miso), .ssel_n(ssel_n), .busy(busy)
    );

    // slave model: reply shifts out on falling sck, mosi captured on rising sck
    logic [15:0] s_resp = '0;
    logic [15:0] s_cap  = '0;
    int          s_cnt  = 0;
    assign miso = s_resp[15];
    always @(negedge sck) s_resp = s_resp << 1;
    always @(posedge sck) begin
        s_cap = {s_cap[14:0], mosi};
        s_cnt = s_cnt + 1;
    end

    // line monitors sampled between edges
    int hi_run = 0, last_hi = 0, lo_run = 0, last_lo = 0, max_lo = 0;
    int sck_hi = 0, last_sck_hi = 0, rises = 0;
    logic prev_ssel = 1'b1;
    always @(negedge clk) begin
        if (ssel_n) begin
            hi_run = hi_run + 1;
            lo_run = 0;
            if (!prev_ssel) rises = rises + 1;
        end else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
            if (!sck) begin
                lo_run = lo_run + 1;
            end else if (lo_run != 0) begin
                last_lo = lo_run;
                if (lo_run > max_lo) max_lo = lo_run;
                lo_run = 0;
            end
        end
        if (sck) begin
            sck_hi = sck_hi + 1;
        end else begin
            if (sck_hi != 0) last_sck_hi = sck_hi;
            sck_hi = 0;
        end
        prev_ssel = ssel_n;
    end

    // {data[15:0], len[3:0], eof, rxign, reply[15:0]}; release flag always set
    localparam int NVEC = 6;
    localparam logic [37:0] VEC [NVEC] = '{
        {16'hA5C3, 4'd15, 1'b0, 1'b0, 16'h3C5A},
        {16'h0001, 4'd0,  1'b0, 1'b0, 16'h0001},
        {16'h00B7, 4'd7,  1'b1, 1'b0, 16'h004E},
        {16'h0155, 4'd8,  1'b0, 1'b1, 16'h01AA},
        {16'h0006, 4'd2,  1'b1, 1'b1, 16'h0005},
        {16'h1234, 4'd12, 1'b0, 1'b0, 16'h0ABC}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] d, input logic [3:0] l,
                        input logic eot, input logic eof, input logic ign);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_data = d; cmd_len = l;
        cmd_eot = eot; cmd_eof = eof; cmd_rxign = ign;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic slave_load(input logic [15:0] v);
        s_resp = v; s_cap = '0; s_cnt = 0; max_lo = 0; rises = 0;
    endtask

    task automatic pop_rx();
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails = fails + 1;
        $display("FAIL R12 watchdog: actual hung expected idle");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0; cmd_len = '0;
        cmd_eot = 1'b0; cmd_eof = 1'b0; cmd_rxign = 1'b0; rx_read = 1'b0;
        half_div = 8'd2; frame_dly = 8'd2; xfer_dly = 8'd1;
        repeat (4) @(negedge clk);
        chk("R13 ssel_n", ssel_n, 1);
        chk("R13 sck", sck, 0);
        chk("R13 busy", busy, 0);
        chk("R13 rx_valid", rx_valid, 0);
        chk("R13 cmd_ready", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1, R2, R8
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] d, r;
            logic [3:0]  l;
            logic        f, g;
            int          msk;
            d = VEC[i][37:22]; l = VEC[i][21:18]; f = VEC[i][17];
            g = VEC[i][16];    r = VEC[i][15:0];
            msk = (1 << (int'(l) + 1)) - 1;
            slave_load(r << (15 - l));
            send(d, l, 1'b1, f, g);
            wait_idle();
            chk("R1 bit count", s_cnt, int'(l) + 1);
            chk("R1 mosi word", int'(s_cap) & msk, int'(d) & msk);
            if (!g) begin
                chk("R2 rx_valid", rx_valid, 1);
                chk("R2 rx_data", rx_data, int'(r) & msk);
                pop_rx();
                chk("R2 rx cleared", rx_valid, 0);
            end else begin
                chk("R8 rx_valid stays low", rx_valid, 0);
            end
        end
        chk("R11 sck high time", last_sck_hi, 3);
        chk("R11 sck low time", last_lo, 3);

        // R4/R10: two words chained with slave select held
        slave_load({8'h5A, 8'hC3});
        send(16'h00E1, 4'd7, 1'b0, 1'b0, 1'b1);
        send(16'h0096, 4'd7, 1'b1, 1'b0, 1'b1);
        chk("R10 second word taken while first shifts", int'(s_cnt < 8), 1);
        wait_idle();
        chk("R4 bits", s_cnt, 16);
        chk("R4 mosi", s_cap, 16'hE196);
        chk("R4 sck low between words", max_lo, 4);
        chk("R4 single release", rises, 1);

        // R5: frame gap with slave select held
        slave_load('0);
        send(16'h0011, 4'd7, 1'b0, 1'b1, 1'b1);
        send(16'h0022, 4'd7, 1'b1, 1'b0, 1'b1);
        wait_idle();
        chk("R5 frame gap low time", max_lo, 16);
        chk("R5 single release", rises, 1);

        // R6: zero frame gap
        frame_dly = 8'd0;
        slave_load('0);
        send(16'h0033, 4'd7, 1'b0, 1'b1, 1'b1);
        send(16'h0044, 4'd7, 1'b1, 1'b0, 1'b1);
        wait_idle();
        chk("R6 zero frame gap", max_lo, 4);

        // R3: post-release gap
        xfer_dly = 8'd3;
        slave_load('0);
        send(16'h0055, 4'd3, 1'b1, 1'b0, 1'b1);
        send(16'h0066, 4'd3, 1'b1, 1'b0, 1'b1);
        wait_idle();
        chk("R3 ssel high time", last_hi, 19);

        // R7: both flags, frame delay larger
        xfer_dly = 8'd1; frame_dly = 8'd3;
        send(16'h0077, 4'd3, 1'b1, 1'b1, 1'b1);
        send(16'h0088, 4'd3, 1'b1, 1'b0, 1'b1);
        wait_idle();
        chk("R7 frame wins", last_hi, 19);
        // R7: both flags, release delay larger
        xfer_dly = 8'd2; frame_dly = 8'd1;
        send(16'h0099, 4'd3, 1'b1, 1'b1, 1'b1);
        send(16'h00AA, 4'd3, 1'b1, 1'b0, 1'b1);
        wait_idle();
        chk("R7 release wins", last_hi, 13);

        // R9: kept-reply word stalls behind unread reply
        xfer_dly = 8'd0; frame_dly = 8'd0;
        slave_load({8'h3E, 8'hD1});
        send(16'h0071, 4'd7, 1'b1, 1'b0, 1'b0);
        send(16'h008C, 4'd7, 1'b1, 1'b0, 1'b0);
        while (!rx_valid) @(negedge clk);
        repeat (40) @(negedge clk);
        chk("R9 stalled ssel_n", ssel_n, 1);
        chk("R9 stalled bits", s_cnt, 8);
        chk("R9 stalled busy", busy, 1);
        chk("R9 first reply", rx_data, 16'h3E);
        pop_rx();
        wait_idle();
        chk("R9 resumed bits", s_cnt, 16);
        chk("R9 resumed mosi", s_cap, 16'h718C);
        chk("R2 second reply", rx_data, 16'hD1);
        pop_rx();

        // R8: discard word runs over unread reply and leaves it intact
        slave_load({8'h66, 8'h99});
        send(16'h0012, 4'd7, 1'b1, 1'b0, 1'b0);
        send(16'h0034, 4'd7, 1'b1, 1'b0, 1'b1);
        wait_idle();
        chk("R8 bits", s_cnt, 16);
        chk("R8 rx_valid kept", rx_valid, 1);
        chk("R8 rx_data kept", rx_data, 16'h66);
        pop_rx();

        // R12: busy holds while slave select stays low with nothing queued
        slave_load('0);
        send(16'h0005, 4'd3, 1'b0, 1'b0, 1'b1);
        while (s_cnt < 4) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R12 busy while selected", busy, 1);
        chk("R12 still selected", ssel_n, 0);
        send(16'h000A, 4'd3, 1'b1, 1'b0, 1'b1);
        wait_idle();
        chk("R12 busy released", busy, 0);
        chk("R12 ssel released", ssel_n, 1);

        // R11: fastest divider
        half_div = 8'd0;
        slave_load('0);
        send(16'h000A, 4'd3, 1'b1, 1'b0, 1'b1);
        wait_idle();
        chk("R11 fast high time", last_sck_hi, 1);
        chk("R11 fast lead time", last_lo, 1);
        chk("R1 fast mosi", int'(s_cap[3:0]), 16'hA);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule